// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block sits between a UART receive shifter and the host side of a serial port. Each finished character arrives on a one-cycle strobe, together with its parity, framing and break flags. The block stores the character and its flags as a single entry in a 16-deep first-in first-out store. The host always sees the oldest entry, and a read strobe removes it.

Two requests tell the host when to come and collect data. The first is a fill-level request. It asserts once the number of held entries reaches a programmable threshold, after a short settling delay measured in 16x sample ticks. The second is an idle timeout. It fires when entries wait unread and no traffic has occurred for four character times.

A single output pin, active low, serves a DMA controller in one of two modes. In the first mode it follows "data present". In the second mode it asserts on either request and stays asserted until the store has been emptied.

With the queue switched off, the block behaves as a single holding register. Any change of the queue-enable input discards everything held.

Top module: `uart_rxq`

## Requirements
- R1: Entries leave in arrival order. `head_char` and its three flags always show the oldest held entry, and the flags stay attached to their own character. `fill` reports the count of held entries, from 0 to 16.
- R2: With `fifo_en` low, at most one entry is held. Any change of `fifo_en` empties the store at the next clock edge.
- R3: `trig_sel` picks the fill-level threshold: 0 selects 1 entry, 1 selects 4, 2 selects 8 and 3 selects 14. With `fifo_en` high, `data_avail` is never high while `fill` is below the threshold, and it drops in the same cycle that a read takes `fill` below the threshold. With `fifo_en` low, `data_avail` rises one cycle after the entry is stored.
- R4: With `fifo_en` high and at least one entry held, `tmo_req` rises after 64 × `frame_bits` sample ticks with no accepted write and no read. A `frame_bits` value of 0 counts as 1. `tmo_req` is never high while `fill` is 0.
- R5: With `fifo_en` high, when a write brings `fill` up to the threshold, `data_avail` rises on the third `tick16` counted after the following clock. When the threshold is reached because `trig_sel` changed, it rises on the eighth such tick. `data_avail` is always low in the cycle after a write into an empty store.
- R6: An accepted write or a host read clears `tmo_req` and restarts the idle count from zero.
- R7: A write while the store is full (16 entries, or 1 with `fifo_en` low) is dropped, and the held entries are unchanged. `overrun` is then set and stays set until the next read or a change of `fifo_en`. A dropped write does not restart the idle count.
- R8: When DMA mode 1 is not in force (`dma_mode` low, or `fifo_en` low), `rxrdy_n` is 0 exactly when `fill` is non-zero.
- R9: With `fifo_en` and `dma_mode` high, `rxrdy_n` goes to 0 when `data_avail` or `tmo_req` is high. It then stays at 0 while `fill` is non-zero, and returns to 1 in the cycle that `fill` reaches 0.
- R10: A read while the store is empty has no effect: `fill` stays 0 and no entry appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push | input | 1 | One-cycle strobe: a received character is complete |
| rx_char | input | CHAR_W | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| tick16 | input | 1 | 16x sample-clock enable |
| frame_bits | input | FRAME_W | Frame length in bit times |
| fifo_en | input | 1 | Queue enable; low selects single holding register |
| trig_sel | input | 2 | Fill-level threshold select |
| dma_mode | input | 1 | DMA pin mode: 0 = data present, 1 = request until empty |
| host_rd | input | 1 | One-cycle host read strobe |
| head_char | output | CHAR_W | Oldest held character |
| head_perr | output | 1 | Parity flag of the oldest entry |
| head_ferr | output | 1 | Framing flag of the oldest entry |
| head_brk | output | 1 | Break flag of the oldest entry |
| fill | output | $clog2(DEPTH+1) | Number of held entries |
| data_avail | output | 1 | Fill-level request |
| tmo_req | output | 1 | Idle timeout request |
| overrun | output | 1 | A write was dropped because the store was full |
| rxrdy_n | output | 1 | DMA request pin, active low |

## Verification
A wrong read or write pointer shows up at the first read after the fault, as a wrong head character or flag set. A wrong occupancy count shows on `fill` in the next cycle. A slip in the fill-level delay counter moves the rising edge of `data_avail` by whole sample ticks. The bench therefore samples that output on the exact cycle before and after the expected edge, for both the write cause and the threshold-change cause. The idle timer is checked the same way at its 448-tick boundary, both from a first write and after a restart. Any wrong state of the DMA hold flag shows on `rxrdy_n` during the partial drain that follows a fill-level request.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'd0,
    TRIG_FOUR     = 2'd1,
    TRIG_EIGHT    = 2'd2,
    TRIG_FOURTEEN = 2'd3
  } rxq_trig_e;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_flags_t;

  // Entry count at which the fill-level request is due.
  function automatic int unsigned rxq_trig_level(input logic [1:0] sel);
    case (sel)
      TRIG_ONE:   return 1;
      TRIG_FOUR:  return 4;
      TRIG_EIGHT: return 8;
      default:    return 14;
    endcase
  endfunction

  // Four character times of sixteen ticks per bit; zero length counts as one bit.
  function automatic int unsigned rxq_tmo_limit(input int unsigned frame_bits);
    int unsigned f;
    f = (frame_bits == 0) ? 1 : frame_bits;
    return f * 64;
  endfunction

endpackage

// File: rtl/uart_rxq_store.sv
`timescale 1ns/1ps
module uart_rxq_store #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fifo_en,
  input  logic                         push,
  input  logic [ENT_W-1:0]             wr_ent,
  input  logic                         rd,
  output logic [ENT_W-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_nxt,
  output logic                         wr_ok,
  output logic                         rd_ok,
  output logic                         clr,
  output logic                         ovr
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             ovr_q;
  logic [CNT_W-1:0] cap;
  logic             drop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign cap   = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign clr   = fifo_en ^ en_q;
  assign wr_ok = push & (cnt_q < cap) & ~clr;
  assign rd_ok = rd & (cnt_q != '0) & ~clr;
  assign drop  = push & ~wr_ok & ~clr;

  always_comb begin
    if (clr)                cnt_nxt = '0;
    else if (wr_ok & ~rd_ok) cnt_nxt = cnt_q + CNT_W'(1);
    else if (rd_ok & ~wr_ok) cnt_nxt = cnt_q - CNT_W'(1);
    else                    cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      en_q  <= fifo_en;
      cnt_q <= cnt_nxt;
      if (clr) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (wr_ok) wp <= ptr_inc(wp);
        if (rd_ok) rp <= ptr_inc(rp);
      end
      if (drop)             ovr_q <= 1'b1;
      else if (clr | rd_ok) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_ent;
  end

  assign head = mem[rp];
  assign cnt  = cnt_q;
  assign ovr  = ovr_q;
endmodule

// File: rtl/uart_rxq_trig.sv
`timescale 1ns/1ps
module uart_rxq_trig
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DLY_WRITE = 3,
  parameter int DLY_LEVEL = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       fifo_en,
  input  logic [1:0]                 trig_sel,
  input  logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       avail
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int DLY_W = $clog2(((DLY_WRITE > DLY_LEVEL) ? DLY_WRITE : DLY_LEVEL) + 1);

  logic [1:0]       trig_q;
  logic             level_hit;
  logic             level_chg;
  logic             start_evt;
  logic             arming;
  logic [DLY_W-1:0] dly;
  logic             avail_q;

  assign level_hit = fifo_en ? (cnt >= CNT_W'(rxq_trig_level(trig_sel))) : (cnt != '0);
  assign level_chg = (trig_sel != trig_q);
  assign start_evt = level_hit & ~avail_q & ~arming;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 2'd0;
      arming  <= 1'b0;
      dly     <= '0;
      avail_q <= 1'b0;
    end else begin
      trig_q <= trig_sel;
      if (!level_hit) begin
        arming  <= 1'b0;
        dly     <= '0;
        avail_q <= 1'b0;
      end else if (start_evt) begin
        if (!fifo_en) begin
          avail_q <= 1'b1;
        end else begin
          arming <= 1'b1;
          dly    <= level_chg ? DLY_W'(DLY_LEVEL) : DLY_W'(DLY_WRITE);
        end
      end else if (arming && tick) begin
        if (dly == DLY_W'(1)) begin
          avail_q <= 1'b1;
          arming  <= 1'b0;
        end
        dly <= dly - DLY_W'(1);
      end
    end
  end

  assign avail = avail_q & level_hit;
endmodule

// File: rtl/uart_rxq_tmo.sv
`timescale 1ns/1ps
module uart_rxq_tmo
  import uart_rxq_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               fifo_en,
  input  logic               busy,
  input  logic               restart,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               tmo
);
  localparam int TMO_W = FRAME_W + 6;

  logic [TMO_W-1:0] limit;
  logic [TMO_W-1:0] idle_cnt;
  logic             tmo_q;
  logic             idle_done;

  assign limit     = TMO_W'(rxq_tmo_limit(32'(frame_bits)));
  assign idle_done = (idle_cnt == limit - TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      tmo_q    <= 1'b0;
    end else if (restart || !fifo_en || !busy) begin
      idle_cnt <= '0;
      tmo_q    <= 1'b0;
    end else if (tick && !tmo_q) begin
      if (idle_done) tmo_q    <= 1'b1;
      else           idle_cnt <= idle_cnt + TMO_W'(1);
    end
  end

  assign tmo = tmo_q;
endmodule

// File: rtl/uart_rxq.sv
`timescale 1ns/1ps
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int CHAR_W  = 8,
  parameter int FRAME_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_push,
  input  logic [CHAR_W-1:0]          rx_char,
  input  logic                       rx_perr,
  input  logic                       rx_ferr,
  input  logic                       rx_brk,
  input  logic                       tick16,
  input  logic [FRAME_W-1:0]         frame_bits,
  input  logic                       fifo_en,
  input  logic [1:0]                 trig_sel,
  input  logic                       dma_mode,
  input  logic                       host_rd,
  output logic [CHAR_W-1:0]          head_char,
  output logic                       head_perr,
  output logic                       head_ferr,
  output logic                       head_brk,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       data_avail,
  output logic                       tmo_req,
  output logic                       overrun,
  output logic                       rxrdy_n
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int ENT_W = CHAR_W + $bits(rxq_flags_t);

  rxq_flags_t       in_flags, out_flags;
  logic [ENT_W-1:0] wr_ent, head_ent;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             wr_ok, rd_ok, clr, ovr;
  logic             avail, tmo;
  logic             dma_req_mode;
  logic             rdy_act;
  logic             hold_q;

  assign in_flags = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr};
  assign wr_ent   = {in_flags, rx_char};

  uart_rxq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .push    (rx_push),
    .wr_ent  (wr_ent),
    .rd      (host_rd),
    .head    (head_ent),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .clr     (clr),
    .ovr     (ovr)
  );

  uart_rxq_trig #(.DEPTH(DEPTH)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .fifo_en  (fifo_en),
    .trig_sel (trig_sel),
    .cnt      (cnt),
    .avail    (avail)
  );

  uart_rxq_tmo #(.FRAME_W(FRAME_W)) u_tmo (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .fifo_en    (fifo_en),
    .busy       (cnt != '0),
    .restart    (wr_ok | rd_ok | clr),
    .frame_bits (frame_bits),
    .tmo        (tmo)
  );

  // DMA mode 1: request on either condition, held until the store drains.
  assign dma_req_mode = fifo_en & dma_mode;
  assign rdy_act      = avail | tmo | hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= dma_req_mode & rdy_act & (cnt_nxt != '0);
  end

  assign out_flags  = rxq_flags_t'(head_ent[ENT_W-1:CHAR_W]);
  assign head_char  = head_ent[CHAR_W-1:0];
  assign head_perr  = out_flags.perr;
  assign head_ferr  = out_flags.ferr;
  assign head_brk   = out_flags.brk;
  assign fill       = cnt;
  assign data_avail = avail;
  assign tmo_req    = tmo;
  assign overrun    = ovr;
  assign rxrdy_n    = dma_req_mode ? ~rdy_act : (cnt == '0);
endmodule

// File: rtl/uart_rxq_chk.sv
`timescale 1ns/1ps
module uart_rxq_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_push,
  input logic                       host_rd,
  input logic                       fifo_en,
  input logic                       dma_mode,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic                       data_avail,
  input logic                       tmo_req,
  input logic                       overrun,
  input logic                       rxrdy_n
);
  localparam int CNT_W = $clog2(DEPTH+1);

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_mode_change_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != $past(fifo_en)) |=> (fill == '0));

  assert_single_holding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !$past(fifo_en)) |-> (fill <= CNT_W'(1)));

  assert_timeout_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_req |-> (fill != '0));

  assert_avail_not_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_push && fill == '0) |=> !data_avail);

  assert_read_clears_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fill != '0) |=> !tmo_req);

  assert_full_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !host_rd && fifo_en && $past(fifo_en) && fill == CNT_W'(DEPTH))
      |=> (overrun && fill == CNT_W'(DEPTH)));

  assert_dma0_follows_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_en && dma_mode) |-> (rxrdy_n == (fill == '0)));

  assert_dma1_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && dma_mode && $past(fifo_en && dma_mode) && $past(!rxrdy_n) && fill != '0)
      |-> !rxrdy_n);
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_push    (rx_push),
  .host_rd    (host_rd),
  .fifo_en    (fifo_en),
  .dma_mode   (dma_mode),
  .fill       (fill),
  .data_avail (data_avail),
  .tmo_req    (tmo_req),
  .overrun    (overrun),
  .rxrdy_n    (rxrdy_n)
);

// File: tb/test_uart_rxq.sv
`timescale 1ns/1ps
module test_uart_rxq;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_push = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic       tick16 = 1'b1;
  logic [3:0] frame_bits = 4'd10;
  logic       fifo_en = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic       dma_mode = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] head_char;
  logic       head_perr, head_ferr, head_brk;
  logic [4:0] fill;
  logic       data_avail, tmo_req, overrun, rxrdy_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [10:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_rxq i_uart_rxq (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_char(rx_char),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .tick16(tick16),
    .frame_bits(frame_bits), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .dma_mode(dma_mode), .host_rd(host_rd), .head_char(head_char),
    .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
    .fill(fill), .data_avail(data_avail), .tmo_req(tmo_req),
    .overrun(overrun), .rxrdy_n(rxrdy_n)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: presents one character and records what the store should hold.
  task automatic push_char(input logic [7:0] c, input logic [2:0] fl);
    @(negedge clk);
    rx_push = 1'b1;
    rx_char = c;
    {rx_brk, rx_ferr, rx_perr} = fl;
    if (exp_q.size() < (fifo_en ? DEPTH : 1)) exp_q.push_back({fl, c});
    @(negedge clk);
    rx_push = 1'b0;
    chk_eq("R1 fill after write", int'(fill), exp_q.size());
  endtask

  // Monitor: compares the head against the scoreboard, then consumes it.
  task automatic pop_char();
    @(negedge clk);
    if (exp_q.size() > 0) begin
      chk_eq("R1 head entry with flags",
             int'({head_brk, head_ferr, head_perr, head_char}), int'(exp_q[0]));
      void'(exp_q.pop_front());
    end
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk_eq("R1 R10 fill after read", int'(fill), exp_q.size());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    chk_eq("reset fill", int'(fill), 0);
    chk_eq("reset data_avail", int'(data_avail), 0);
    chk_eq("reset tmo_req", int'(tmo_req), 0);
    chk_eq("reset overrun", int'(overrun), 0);
    chk_eq("reset rxrdy_n", int'(rxrdy_n), 1);

    // R2 / R3 / R7: single holding register
    push_char(8'hA1, 3'b001);
    chk_eq("R3 no-queue avail not yet", int'(data_avail), 0);
    wait_cyc(1);
    chk_eq("R3 no-queue avail after one cycle", int'(data_avail), 1);
    chk_eq("R8 rxrdy_n with data", int'(rxrdy_n), 0);
    push_char(8'hB2, 3'b000);
    chk_eq("R2 R7 overrun on second write", int'(overrun), 1);
    pop_char();
    chk_eq("R7 overrun cleared by read", int'(overrun), 0);

    // R3 / R5: threshold of four, write cause
    fifo_en = 1'b1;
    trig_sel = 2'd1;
    wait_cyc(2);
    push_char(8'h10, 3'b010);
    push_char(8'h11, 3'b100);
    push_char(8'h12, 3'b000);
    chk_eq("R3 below threshold", int'(data_avail), 0);
    push_char(8'h13, 3'b111);
    wait_cyc(3);
    chk_eq("R5 avail before third tick", int'(data_avail), 0);
    wait_cyc(1);
    chk_eq("R5 avail on third tick", int'(data_avail), 1);
    chk_eq("R8 mode0 rxrdy_n", int'(rxrdy_n), 0);
    pop_char();
    chk_eq("R3 avail drops below threshold", int'(data_avail), 0);
    wait_cyc(2);

    // R5: threshold change cause
    trig_sel = 2'd0;
    wait_cyc(8);
    chk_eq("R5 level change before eighth tick", int'(data_avail), 0);
    wait_cyc(1);
    chk_eq("R5 level change on eighth tick", int'(data_avail), 1);
    pop_char();
    pop_char();
    pop_char();

    // R1 / R3 / R7 / R10: full store
    trig_sel = 2'd3;
    wait_cyc(2);
    for (int i = 0; i < 13; i++) push_char(8'(8'h40 + i), 3'(i));
    wait_cyc(6);
    chk_eq("R3 thirteen below fourteen", int'(data_avail), 0);
    for (int i = 13; i < 16; i++) push_char(8'(8'h40 + i), 3'(i));
    wait_cyc(6);
    chk_eq("R3 avail at sixteen", int'(data_avail), 1);
    chk_eq("R1 fill at depth", int'(fill), 16);
    push_char(8'hEE, 3'b111);
    chk_eq("R7 overrun when full", int'(overrun), 1);
    pop_char();
    chk_eq("R7 overrun cleared after read", int'(overrun), 0);
    for (int i = 1; i < 16; i++) pop_char();
    pop_char();
    chk_eq("R10 empty read keeps fill", int'(fill), 0);

    // R4 / R6: idle timeout, 64 * 7 = 448 ticks
    frame_bits = 4'd7;
    wait_cyc(2);
    push_char(8'h55, 3'b000);
    wait_cyc(447);
    chk_eq("R4 timeout just before limit", int'(tmo_req), 0);
    wait_cyc(1);
    chk_eq("R4 timeout at limit", int'(tmo_req), 1);
    pop_char();
    chk_eq("R6 read clears timeout", int'(tmo_req), 0);
    push_char(8'h56, 3'b001);
    wait_cyc(299);
    push_char(8'h57, 3'b010);
    wait_cyc(447);
    chk_eq("R6 write restarts idle count", int'(tmo_req), 0);
    wait_cyc(1);
    chk_eq("R6 timeout after restart", int'(tmo_req), 1);
    pop_char();
    pop_char();

    // R9: DMA mode 1
    dma_mode = 1'b1;
    trig_sel = 2'd1;
    wait_cyc(2);
    push_char(8'h60, 3'b000);
    push_char(8'h61, 3'b000);
    push_char(8'h62, 3'b000);
    chk_eq("R9 no request below threshold", int'(rxrdy_n), 1);
    push_char(8'h63, 3'b000);
    wait_cyc(5);
    chk_eq("R9 request at threshold", int'(rxrdy_n), 0);
    pop_char();
    chk_eq("R9 held below threshold", int'(rxrdy_n), 0);
    pop_char();
    pop_char();
    chk_eq("R9 held with one entry", int'(rxrdy_n), 0);
    pop_char();
    chk_eq("R9 released when empty", int'(rxrdy_n), 1);

    // R2 / R8: disabling the queue discards entries
    dma_mode = 1'b0;
    for (int i = 0; i < 5; i++) push_char(8'(8'h70 + i), 3'b000);
    chk_eq("R8 mode0 rxrdy_n with data", int'(rxrdy_n), 0);
    fifo_en = 1'b0;
    exp_q.delete();
    wait_cyc(1);
    chk_eq("R2 disable empties store", int'(fill), 0);
    chk_eq("R8 rxrdy_n after clear", int'(rxrdy_n), 1);

    wait_cyc(2);
    finish_run();
  end
endmodule